// File: doc/BRIEF.md
# Flow Identifier CRC-32 Hasher

This block turns a parsed packet header into a 32-bit flow identifier. A header descriptor arrives over a valid/ready handshake and carries the IP version, the layer-4 kind, both IP addresses, the protocol or next-header byte, the L4 ports and, for TCP, the header length, flags, window and urgent pointer. The block lays these fields out as a fixed, protocol-dependent sequence of zero-padded 32-bit words and folds one word per clock into a CRC-32 register.

When the header says that TCP options follow, the block opens a second valid/ready stream and takes option words one at a time until a word marked last. Words marked as the timestamp option are taken without stalling but leave the CRC untouched. One cycle after the final word is taken, a single-cycle done strobe rises together with the finished identifier, and the block is ready for the next header in that same cycle.

Top module: `flow_hash_crc32`

## Requirements
- R1: With `hdr_is_v6`=0 the hashed words are, in order, the destination address (`hdr_dst_addr[31:0]`), the source address (`hdr_src_addr[31:0]`), and {24 zero bits, `hdr_proto`}.
- R2: With `hdr_is_v6`=1 the hashed words are the four words of the 128-bit destination address from bits [127:96] down to [31:0], then the four words of the source address in the same order, then {24 zero bits, `hdr_proto`}.
- R3: With `hdr_l4`=1 (UDP) one word {`hdr_src_port`, `hdr_dst_port`} follows the IP words.
- R4: With `hdr_l4`=2 (TCP) three words follow the IP words: {`hdr_src_port`, `hdr_dst_port`}, then {`hdr_tcp_len`, 6 zero bits, `hdr_tcp_flags`, `hdr_tcp_win`}, then {16 zero bits, `hdr_tcp_urg`}; `hdr_l4` values 0 and 3 add no L4 words.
- R5: With `hdr_l4`=2 and `hdr_tcp_opts`=1, option words taken after the fixed words are hashed in arrival order, except words with `opt_is_ts`=1, which change nothing; the word with `opt_last`=1 ends the flow whatever its `opt_is_ts`.
- R6: The CRC is the reflected CRC-32 (polynomial 0x04C11DB7, bit-reversed form 0xEDB88320), initial value 0xFFFFFFFF, final inversion, each word fed most significant byte first, each byte least significant bit first.
- R7: `flow_done` is a one-cycle pulse that rises one cycle after the last word is taken, i.e. N cycles after the header handshake for a flow of N fixed words and no option phase; `flow_hash` holds its value between pulses.
- R8: `hdr_ready` is high after reset and whenever no flow is in progress, drops for the cycles after a header handshake, and is high again in the cycle `flow_done` is high.
- R9: `opt_ready` is high only during the option phase of a TCP flow with options; option inputs offered at any other time have no effect on the hash or on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header descriptor offered |
| hdr_ready | output | 1 | Header descriptor taken when both high |
| hdr_is_v6 | input | 1 | 1 for IPv6, 0 for IPv4 |
| hdr_l4 | input | 2 | 0 none, 1 UDP, 2 TCP, 3 none |
| hdr_tcp_opts | input | 1 | TCP option words follow on the option stream |
| hdr_dst_addr | input | 128 | Destination address (IPv4 in [31:0]) |
| hdr_src_addr | input | 128 | Source address (IPv4 in [31:0]) |
| hdr_proto | input | 8 | Protocol or next-header value |
| hdr_src_port | input | 16 | L4 source port |
| hdr_dst_port | input | 16 | L4 destination port |
| hdr_tcp_len | input | 4 | TCP header length |
| hdr_tcp_flags | input | 6 | TCP flags |
| hdr_tcp_win | input | 16 | TCP window |
| hdr_tcp_urg | input | 16 | TCP urgent pointer |
| opt_valid | input | 1 | Option word offered |
| opt_ready | output | 1 | Option word taken when both high |
| opt_word | input | 32 | Option word |
| opt_is_ts | input | 1 | Word belongs to the timestamp option |
| opt_last | input | 1 | Final option word of the flow |
| flow_done | output | 1 | One-cycle completion strobe |
| flow_hash | output | 32 | Flow identifier, valid with flow_done |

## Verification
A wrong step counter or word selector shifts, drops or repeats a padded word, so the identifier differs from the reference on the first flow of the affected IP/L4 kind, and the done pulse also moves by whole cycles. A CRC register that absorbs a timestamp word, or misses the reset of its seed between flows, is visible in the very next identifier. A state machine that leaves the option phase early or late shows up at once as a wrong `opt_ready` or `hdr_ready` level, or as a done pulse that arrives a cycle off.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;

  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 128;
  localparam int ADDR_WORDS = ADDR_W / WORD_W;
  localparam int BYTE_W     = 8;
  localparam int BYTES      = WORD_W / BYTE_W;
  localparam int V4_WORDS   = 3;
  localparam int V6_WORDS   = 2 * ADDR_WORDS + 1;
  localparam int TCP_WORDS  = 3;
  localparam int UDP_WORDS  = 1;
  localparam int MAX_FIX    = V6_WORDS + TCP_WORDS;
  localparam int STEP_W     = $clog2(MAX_FIX + 1);

  localparam logic [WORD_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [WORD_W-1:0] CRC_SEED      = '1;

  typedef enum logic [1:0] {
    L4_NONE = 2'd0,
    L4_UDP  = 2'd1,
    L4_TCP  = 2'd2,
    L4_RSVD = 2'd3
  } l4_kind_e;

  typedef struct packed {
    logic              is_v6;
    l4_kind_e          l4;
    logic              has_opts;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [7:0]        proto;
    logic [15:0]       sport;
    logic [15:0]       dport;
    logic [3:0]        tlen;
    logic [5:0]        tflags;
    logic [15:0]       twin;
    logic [15:0]       turg;
  } flow_hdr_t;

  function automatic int ip_words(input logic is_v6);
    return is_v6 ? V6_WORDS : V4_WORDS;
  endfunction

  function automatic int l4_words(input l4_kind_e k);
    case (k)
      L4_UDP:  return UDP_WORDS;
      L4_TCP:  return TCP_WORDS;
      default: return 0;
    endcase
  endfunction

  // One byte into a reflected CRC register.
  function automatic logic [WORD_W-1:0] crc_byte(input logic [WORD_W-1:0] c,
                                                 input logic [BYTE_W-1:0] d);
    logic [WORD_W-1:0] r;
    r = c ^ {{(WORD_W-BYTE_W){1'b0}}, d};
    for (int i = 0; i < BYTE_W; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction

  // One word, most significant byte first.
  function automatic logic [WORD_W-1:0] crc_word(input logic [WORD_W-1:0] c,
                                                 input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = c;
    for (int b = BYTES - 1; b >= 0; b--)
      r = crc_byte(r, w[b*BYTE_W +: BYTE_W]);
    return r;
  endfunction

  // Padded header word at position step of the fixed sequence.
  function automatic logic [WORD_W-1:0] hdr_word(input flow_hdr_t h,
                                                 input logic [STEP_W-1:0] step);
    int s;
    int nip;
    int k;
    s   = int'(step);
    nip = ip_words(h.is_v6);
    if (s < nip) begin
      if (h.is_v6) begin
        if (s < ADDR_WORDS)
          return h.dst[ADDR_W-1-s*WORD_W -: WORD_W];
        else if (s < 2 * ADDR_WORDS)
          return h.src[ADDR_W-1-(s-ADDR_WORDS)*WORD_W -: WORD_W];
        else
          return {24'd0, h.proto};
      end else begin
        case (s)
          0:       return h.dst[WORD_W-1:0];
          1:       return h.src[WORD_W-1:0];
          default: return {24'd0, h.proto};
        endcase
      end
    end
    k = s - nip;
    case (k)
      0:       return {h.sport, h.dport};
      1:       return {h.tlen, 6'd0, h.tflags, h.twin};
      default: return {16'd0, h.turg};
    endcase
  endfunction

endpackage

// File: rtl/flow_word_seq.sv
module flow_word_seq
  import flow_hash_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  flow_hdr_t         hdr_in,
  output logic              hdr_ready,
  input  logic              opt_valid,
  input  logic [WORD_W-1:0] opt_word,
  input  logic              opt_is_ts,
  input  logic              opt_last,
  output logic              opt_ready,
  output logic              seq_start,
  output logic              seq_upd,
  output logic              seq_end,
  output logic [WORD_W-1:0] seq_word
);

  typedef enum logic [1:0] {ST_IDLE, ST_FIX, ST_OPT} seq_state_e;

  seq_state_e        state_q;
  flow_hdr_t         hdr_q;
  logic [STEP_W-1:0] step_q;
  logic              fix_last;
  logic              go_opts;
  int                nfix;

  always_comb begin
    nfix      = ip_words(hdr_q.is_v6) + l4_words(hdr_q.l4);
    go_opts   = (hdr_q.l4 == L4_TCP) && hdr_q.has_opts;
    hdr_ready = 1'b0;
    opt_ready = 1'b0;
    seq_start = 1'b0;
    seq_upd   = 1'b0;
    seq_end   = 1'b0;
    fix_last  = 1'b0;
    seq_word  = '0;
    case (state_q)
      ST_IDLE: begin
        hdr_ready = 1'b1;
        seq_start = hdr_valid;
      end
      ST_FIX: begin
        seq_word = hdr_word(hdr_q, step_q);
        seq_upd  = 1'b1;
        fix_last = (int'(step_q) == nfix - 1);
        seq_end  = fix_last && !go_opts;
      end
      ST_OPT: begin
        opt_ready = 1'b1;
        seq_word  = opt_word;
        seq_upd   = opt_valid && !opt_is_ts;
        seq_end   = opt_valid && opt_last;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (hdr_valid) begin
          hdr_q   <= hdr_in;
          step_q  <= '0;
          state_q <= ST_FIX;
        end
        ST_FIX: begin
          step_q <= step_q + 1'b1;
          if (fix_last) state_q <= go_opts ? ST_OPT : ST_IDLE;
        end
        ST_OPT: if (seq_end) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flow_crc_acc.sv
module flow_crc_acc
  import flow_hash_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              upd,
  input  logic              fin,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] crc_q,
  output logic              done,
  output logic [WORD_W-1:0] hash
);

  logic [WORD_W-1:0] crc_nx;
  logic [WORD_W-1:0] crc_sel;

  assign crc_nx  = crc_word(crc_q, word);
  assign crc_sel = upd ? crc_nx : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
      done  <= 1'b0;
      hash  <= '0;
    end else begin
      done <= fin;
      if (start)    crc_q <= CRC_SEED;
      else if (upd) crc_q <= crc_nx;
      if (fin)      hash  <= ~crc_sel;
    end
  end

endmodule

// File: rtl/flow_hash_crc32.sv
module flow_hash_crc32
  import flow_hash_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic          hdr_is_v6,
  input  logic [1:0]    hdr_l4,
  input  logic          hdr_tcp_opts,
  input  logic [127:0]  hdr_dst_addr,
  input  logic [127:0]  hdr_src_addr,
  input  logic [7:0]    hdr_proto,
  input  logic [15:0]   hdr_src_port,
  input  logic [15:0]   hdr_dst_port,
  input  logic [3:0]    hdr_tcp_len,
  input  logic [5:0]    hdr_tcp_flags,
  input  logic [15:0]   hdr_tcp_win,
  input  logic [15:0]   hdr_tcp_urg,
  input  logic          opt_valid,
  output logic          opt_ready,
  input  logic [31:0]   opt_word,
  input  logic          opt_is_ts,
  input  logic          opt_last,
  output logic          flow_done,
  output logic [31:0]   flow_hash
);

  flow_hdr_t         hdr_in;
  logic              seq_start;
  logic              seq_upd;
  logic              seq_end;
  logic [WORD_W-1:0] seq_word;
  logic [WORD_W-1:0] crc_q;

  always_comb begin
    hdr_in.is_v6    = hdr_is_v6;
    hdr_in.l4       = l4_kind_e'(hdr_l4);
    hdr_in.has_opts = hdr_tcp_opts;
    hdr_in.dst      = hdr_dst_addr;
    hdr_in.src      = hdr_src_addr;
    hdr_in.proto    = hdr_proto;
    hdr_in.sport    = hdr_src_port;
    hdr_in.dport    = hdr_dst_port;
    hdr_in.tlen     = hdr_tcp_len;
    hdr_in.tflags   = hdr_tcp_flags;
    hdr_in.twin     = hdr_tcp_win;
    hdr_in.turg     = hdr_tcp_urg;
  end

  flow_word_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_in    (hdr_in),
    .hdr_ready (hdr_ready),
    .opt_valid (opt_valid),
    .opt_word  (opt_word),
    .opt_is_ts (opt_is_ts),
    .opt_last  (opt_last),
    .opt_ready (opt_ready),
    .seq_start (seq_start),
    .seq_upd   (seq_upd),
    .seq_end   (seq_end),
    .seq_word  (seq_word)
  );

  flow_crc_acc crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (seq_start),
    .upd   (seq_upd),
    .fin   (seq_end),
    .word  (seq_word),
    .crc_q (crc_q),
    .done  (flow_done),
    .hash  (flow_hash)
  );

endmodule

// File: rtl/flow_hash_chk.sv
module flow_hash_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_valid,
  input logic        hdr_ready,
  input logic        opt_valid,
  input logic        opt_ready,
  input logic        opt_is_ts,
  input logic        opt_last,
  input logic        flow_done,
  input logic [31:0] flow_hash,
  input logic        seq_end,
  input logic [31:0] crc_q
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_done |=> !flow_done);

  // R7
  done_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> flow_done);

  // R7
  hash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_end |=> $stable(flow_hash));

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_done |-> hdr_ready);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> !hdr_ready);

  // R9
  opt_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opt_ready |-> !hdr_ready);

  // R5
  ts_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_ready && opt_valid && opt_is_ts && !opt_last) |=> $stable(crc_q));

endmodule

bind flow_hash_crc32 flow_hash_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .hdr_valid (hdr_valid),
  .hdr_ready (hdr_ready),
  .opt_valid (opt_valid),
  .opt_ready (opt_ready),
  .opt_is_ts (opt_is_ts),
  .opt_last  (opt_last),
  .flow_done (flow_done),
  .flow_hash (flow_hash),
  .seq_end   (seq_end),
  .crc_q     (crc_q)
);

// File: tb/flow_hash_crc32_tb_top.sv
`timescale 1ns/1ps
module flow_hash_crc32_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hdr_valid = 1'b0;
  logic         hdr_ready;
  logic         hdr_is_v6 = 1'b0;
  logic [1:0]   hdr_l4 = 2'd0;
  logic         hdr_tcp_opts = 1'b0;
  logic [127:0] hdr_dst_addr = '0;
  logic [127:0] hdr_src_addr = '0;
  logic [7:0]   hdr_proto = '0;
  logic [15:0]  hdr_src_port = '0;
  logic [15:0]  hdr_dst_port = '0;
  logic [3:0]   hdr_tcp_len = '0;
  logic [5:0]   hdr_tcp_flags = '0;
  logic [15:0]  hdr_tcp_win = '0;
  logic [15:0]  hdr_tcp_urg = '0;
  logic         opt_valid = 1'b0;
  logic         opt_ready;
  logic [31:0]  opt_word = '0;
  logic         opt_is_ts = 1'b0;
  logic         opt_last = 1'b0;
  logic         flow_done;
  logic [31:0]  flow_hash;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [31:0] ref_w [0:63];
  int          ref_n;
  logic [31:0] ow    [0:15];
  logic        ots   [0:15];
  int          n_opt;

  always #2.5 clk = ~clk;

  flow_hash_crc32 dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  // Reference CRC: non-reflected shift register fed LSB-first, result reversed.
  function automatic logic [31:0] ref_crc();
    logic [31:0] c;
    logic [31:0] r;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < ref_n; i++)
      for (int b = 3; b >= 0; b--)
        for (int k = 0; k < 8; k++) begin
          fb = c[31] ^ ref_w[i][b*8+k];
          c  = {c[30:0], 1'b0};
          if (fb) c = c ^ 32'h04C1_1DB7;
        end
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    return ~r;
  endfunction

  function automatic void push(input logic [31:0] w);
    ref_w[ref_n] = w;
    ref_n++;
  endfunction

  // Build the expected word list from the requirements (R1..R5).
  function automatic void build_ref();
    ref_n = 0;
    if (hdr_is_v6) begin
      push(hdr_dst_addr[127:96]); push(hdr_dst_addr[95:64]);
      push(hdr_dst_addr[63:32]);  push(hdr_dst_addr[31:0]);
      push(hdr_src_addr[127:96]); push(hdr_src_addr[95:64]);
      push(hdr_src_addr[63:32]);  push(hdr_src_addr[31:0]);
    end else begin
      push(hdr_dst_addr[31:0]);
      push(hdr_src_addr[31:0]);
    end
    push({24'd0, hdr_proto});
    if (hdr_l4 == 2'd1 || hdr_l4 == 2'd2) push({hdr_src_port, hdr_dst_port});
    if (hdr_l4 == 2'd2) begin
      push({hdr_tcp_len, 6'd0, hdr_tcp_flags, hdr_tcp_win});
      push({16'd0, hdr_tcp_urg});
      if (hdr_tcp_opts)
        for (int i = 0; i < n_opt; i++)
          if (!ots[i]) push(ow[i]);
    end
  endfunction

  function automatic void rand_hdr();
    hdr_dst_addr  = {$urandom, $urandom, $urandom, $urandom};
    hdr_src_addr  = {$urandom, $urandom, $urandom, $urandom};
    hdr_proto     = 8'($urandom);
    hdr_src_port  = 16'($urandom);
    hdr_dst_port  = 16'($urandom);
    hdr_tcp_len   = 4'($urandom);
    hdr_tcp_flags = 6'($urandom);
    hdr_tcp_win   = 16'($urandom);
    hdr_tcp_urg   = 16'($urandom);
  endfunction

  // Caller is at a negedge. junk drives option inputs while no option phase exists.
  task automatic run_flow(input string req, input bit junk);
    int  cnt;
    int  nfix;
    bit  opt_phase;
    logic [31:0] exp_h;
    opt_phase = (hdr_l4 == 2'd2) && hdr_tcp_opts;
    nfix = (hdr_is_v6 ? 9 : 3) + ((hdr_l4 == 2'd1) ? 1 : (hdr_l4 == 2'd2) ? 3 : 0);
    build_ref();
    exp_h = ref_crc();
    if (junk) begin
      opt_valid = 1'b1; opt_last = 1'b1; opt_is_ts = 1'b0; opt_word = $urandom;
    end
    hdr_valid = 1'b1;
    while (!hdr_ready) @(negedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    if (opt_phase) begin
      for (int i = 0; i < n_opt; i++) begin
        opt_valid = 1'b1; opt_word = ow[i]; opt_is_ts = ots[i];
        opt_last  = (i == n_opt - 1);
        forever begin
          if (opt_ready) begin
            @(negedge clk);
            break;
          end
          @(negedge clk);
        end
      end
      opt_valid = 1'b0; opt_last = 1'b0; opt_is_ts = 1'b0;
    end
    cnt = 0;
    while (!flow_done && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    // R7: done N cycles after the header for no option phase, next cycle after last option otherwise
    check("R7 done latency", cnt, opt_phase ? 0 : nfix);
    check(req, flow_hash, exp_h);
    // R8: ready again together with done
    check("R8 ready at done", {31'd0, hdr_ready}, 32'd1);
    opt_valid = 1'b0; opt_last = 1'b0;
    @(negedge clk);
    // R7: single-cycle pulse
    check("R7 done pulse", {31'd0, flow_done}, 32'd0);
  endtask

  initial begin
    logic [4:0] ts_mask [0:4];
    int         ts_n    [0:4];
    string      tag;
    ts_mask[0] = 5'b00000; ts_n[0] = 1;
    ts_mask[1] = 5'b00010; ts_n[1] = 2;
    ts_mask[2] = 5'b00010; ts_n[2] = 3;
    ts_mask[3] = 5'b00011; ts_n[3] = 2;
    ts_mask[4] = 5'b00001; ts_n[4] = 4;
    n_opt = 0;

    repeat (3) @(negedge clk);
    // R8 / R9 / R7: reset state
    check("R8 reset hdr_ready", {31'd0, hdr_ready}, 32'd1);
    check("R9 reset opt_ready", {31'd0, opt_ready}, 32'd0);
    check("R7 reset flow_done", {31'd0, flow_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2 IP kinds x R3/R4 L4 kinds, with R9 junk option traffic on odd reps (R6 via reference)
    for (int v6 = 0; v6 < 2; v6++)
      for (int l4 = 0; l4 < 4; l4++)
        for (int rep = 0; rep < 4; rep++) begin
          hdr_is_v6 = v6[0]; hdr_l4 = l4[1:0]; hdr_tcp_opts = 1'b0;
          rand_hdr();
          if (rep == 2) begin
            hdr_dst_addr = '0; hdr_src_addr = '0; hdr_proto = '0;
          end
          if (rep == 3) begin
            hdr_dst_addr = '1; hdr_src_addr = '1; hdr_proto = '1;
            hdr_tcp_flags = '1; hdr_tcp_len = '1;
          end
          tag = (l4 == 1) ? "R3 udp hash" : (l4 == 2) ? "R4 tcp hash" :
                (v6 != 0) ? "R2 v6 hash" : "R1 v4 hash";
          run_flow(tag, rep[0]);
        end

    // R5: TCP options with timestamp words in several positions
    for (int v6 = 0; v6 < 2; v6++)
      for (int p = 0; p < 5; p++) begin
        hdr_is_v6 = v6[0]; hdr_l4 = 2'd2; hdr_tcp_opts = 1'b1;
        rand_hdr();
        n_opt = ts_n[p];
        for (int i = 0; i < n_opt; i++) begin
          ow[i]  = $urandom;
          ots[i] = ts_mask[p][i];
        end
        run_flow("R5 tcp options hash", 1'b0);
      end

    // R4: TCP without the options flag ignores the option stream (R9)
    hdr_is_v6 = 1'b0; hdr_l4 = 2'd2; hdr_tcp_opts = 1'b0;
    rand_hdr();
    run_flow("R9 opts flag clear", 1'b1);

    finish_run();
  end

endmodule